// File: doc/BRIEF.md
# Multi-Mode Cascadable Timer Channel

One 16-bit counter channel with a reload register. The same counter serves three jobs, chosen by a two-bit mode field. In interval mode it counts down on one of four prescaled clock-enable strobes. In event mode it counts down on edges of an external pin, or on overflow pulses from a neighbouring channel. In measurement mode it counts up between edges of the external pin and captures the elapsed count on each qualifying edge. This gives either the period of the pin's signal or the width of its high and low phases.

Software loads the reload register through two byte-wide write strobes. While the channel is stopped, a write also lands in the counter, so the first interval is set by that write. The overflow output of a channel can feed the neighbour-overflow input of the next channel, so channels can be chained into longer counters. The wiring of that ring lies outside the channel. The prescaler that makes the clock-enable strobes and the interrupt controller that takes the request pulse are also outside the channel.

Top module: `mtc_chan`

## Requirements
- R1: After reset, `count_o` and `reload_o` are zero, and `irq` and `ovf_o` are low.
- R2: While `start` is low, `wr_lo` writes `wr_data` into bits 7:0 of both the reload register and the counter. `wr_hi` does the same for bits 15:8.
- R3: While `start` is high, a byte write changes only the reload register. The counter is left as it was.
- R4: In interval mode (`mode` = 00), each pulse of the strobe picked by `clk_sel` lowers the count by one. The encoding is 00 for `en_f1`, 01 for `en_f8`, 10 for `en_f32` and 11 for `en_fc32`. Pulses on the other strobes have no effect.
- R5: In interval or event mode, a count step taken at zero loads the count from the reload register. In the cycle after that clock edge, `irq` and `ovf_o` are both high for exactly one cycle. A reload value of N therefore gives one request every N+1 steps.
- R6: While `start` is low and no write occurs, the count holds, whatever the strobes and pins do.
- R7: In event mode (`mode` = 01) with `clk_sel[1]` = 0, the count steps on the active edge of `ext_in`. The active edge is rising when `edge_pol` = 1 and falling when `edge_pol` = 0. The step is taken at the third rising clock edge after the pin changes. The opposite edge has no effect. With `clk_sel[1]` = 1, each cycle in which `nbr_ovf` is high counts as one step.
- R8: In measurement mode (`mode` = 10) with `width_meas` = 0, the count rises by one per selected strobe. The strobe is chosen by `clk_sel` as in R4. On an active pin edge, timed as in R7, the count is copied into `reload_o`, the count is cleared, and `irq` pulses high while `ovf_o` stays low. The opposite edge has no effect.
- R9: In measurement mode with `width_meas` = 1, both pin edges capture and clear as in R8.
- R10: With `mode` = 11 and `start` high, the count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Run enable |
| mode | input | 2 | 00 interval, 01 event, 10 measurement, 11 reserved |
| clk_sel | input | 2 | Strobe select; bit 1 also selects the event source |
| edge_pol | input | 1 | Active pin edge: 1 rising, 0 falling |
| width_meas | input | 1 | Measurement: 0 period, 1 width |
| en_f1 | input | 1 | Fastest clock-enable strobe |
| en_f8 | input | 1 | Clock-enable strobe, divide by 8 |
| en_f32 | input | 1 | Clock-enable strobe, divide by 32 |
| en_fc32 | input | 1 | Clock-enable strobe from the slow clock |
| ext_in | input | 1 | External event or measured pin (asynchronous) |
| nbr_ovf | input | 1 | Overflow pulse from the neighbouring channel |
| wr_lo | input | 1 | Write low byte |
| wr_hi | input | 1 | Write high byte |
| wr_data | input | 8 | Write data byte |
| count_o | output | 16 | Live counter value |
| reload_o | output | 16 | Reload register / captured measurement |
| irq | output | 1 | Interrupt request pulse |
| ovf_o | output | 1 | Underflow pulse towards the next channel |

## Verification
The hardest situation to reach is a capture edge that is timed correctly through the pin synchronizer. It has to arrive after a known number of strobes, while the opposite edge is seen to be ignored. The bench reaches it with directed steps. It holds the strobes low while the pin edge passes through the synchronizer, counts clock edges to the capture, and then checks `reload_o`, `count_o` and the request pulse in that cycle. The wrap arithmetic of repeated underflows is covered by random strobe patterns against random small reload values. The bench compares the final count and the number of request pulses with closed-form functions.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  typedef enum logic [1:0] {
    MD_INTERVAL = 2'b00,
    MD_EVENT    = 2'b01,
    MD_MEASURE  = 2'b10,
    MD_RSVD     = 2'b11
  } mtc_mode_e;
endpackage

// File: rtl/mtc_edge_det.sv
module mtc_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic pol,
  output logic act_edge,
  output logic any_edge
);
  logic [SYNC_STAGES:0] sh;
  logic cur, prv, rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC_STAGES-1:0], pin};
  end

  assign cur      = sh[SYNC_STAGES-1];
  assign prv      = sh[SYNC_STAGES];
  assign rise     = cur & ~prv;
  assign fall     = ~cur & prv;
  assign act_edge = pol ? rise : fall;
  assign any_edge = rise | fall;
endmodule

// File: rtl/mtc_tick_sel.sv
module mtc_tick_sel
  import mtc_pkg::*;
(
  input  mtc_mode_e  mode,
  input  logic [1:0] clk_sel,
  input  logic [3:0] strobes,
  input  logic       ext_edge,
  input  logic       nbr_ovf,
  output logic       tick
);
  always_comb begin
    unique case (mode)
      MD_INTERVAL, MD_MEASURE: tick = strobes[clk_sel];
      MD_EVENT:                tick = clk_sel[1] ? nbr_ovf : ext_edge;
      default:                 tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/mtc_counter.sv
module mtc_counter
  import mtc_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mtc_mode_e         mode,
  input  logic              width_meas,
  input  logic              tick,
  input  logic              act_edge,
  input  logic              any_edge,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  reload,
  output logic              uflow_evt,
  output logic              cap_evt
);
  function automatic logic [CNT_W-1:0] merge_bytes(
    input logic [CNT_W-1:0] old, input logic [BYTE_W-1:0] d,
    input logic lo, input logic hi);
    logic [CNT_W-1:0] r;
    r = old;
    if (lo) r[BYTE_W-1:0]     = d;
    if (hi) r[CNT_W-1:BYTE_W] = d;
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] step_down(
    input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] rl);
    return (c == '0) ? rl : c - 1'b1;
  endfunction

  logic down_mode;
  assign down_mode = (mode == MD_INTERVAL) || (mode == MD_EVENT);
  assign uflow_evt = start && down_mode && tick && (count == '0);
  assign cap_evt   = start && (mode == MD_MEASURE) &&
                     (width_meas ? any_edge : act_edge);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload <= '0;
    end else if (cap_evt) begin
      reload <= count;
    end else begin
      reload <= merge_bytes(reload, wr_data, wr_lo, wr_hi);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (!start) begin
      count <= merge_bytes(count, wr_data, wr_lo, wr_hi);
    end else if (down_mode) begin
      if (tick) count <= step_down(count, reload);
    end else if (mode == MD_MEASURE) begin
      if (cap_evt)   count <= '0;
      else if (tick) count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/mtc_chan.sv
module mtc_chan
  import mtc_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [1:0]        clk_sel,
  input  logic              edge_pol,
  input  logic              width_meas,
  input  logic              en_f1,
  input  logic              en_f8,
  input  logic              en_f32,
  input  logic              en_fc32,
  input  logic              ext_in,
  input  logic              nbr_ovf,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              irq,
  output logic              ovf_o
);
  mtc_mode_e  mode_e;
  logic [3:0] strobes;
  logic act_edge, any_edge, tick, uflow_evt, cap_evt;

  assign mode_e  = mtc_mode_e'(mode);
  assign strobes = {en_fc32, en_f32, en_f8, en_f1};

  mtc_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(ext_in), .pol(edge_pol),
    .act_edge(act_edge), .any_edge(any_edge));

  mtc_tick_sel u_tick (
    .mode(mode_e), .clk_sel(clk_sel), .strobes(strobes),
    .ext_edge(act_edge), .nbr_ovf(nbr_ovf), .tick(tick));

  mtc_counter #(.BYTE_W(BYTE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode_e),
    .width_meas(width_meas), .tick(tick), .act_edge(act_edge),
    .any_edge(any_edge), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .count(count_o), .reload(reload_o), .uflow_evt(uflow_evt),
    .cap_evt(cap_evt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq   <= 1'b0;
      ovf_o <= 1'b0;
    end else begin
      irq   <= uflow_evt | cap_evt;
      ovf_o <= uflow_evt;
    end
  end
endmodule

// File: rtl/mtc_chan_chk.sv
module mtc_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [1:0]       mode,
  input logic             wr_lo,
  input logic             wr_hi,
  input logic             tick,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] reload_o,
  input logic             irq,
  input logic             ovf_o
);
  AST_OVF_HAS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> irq); // R5

  AST_UFLOW_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode == 2'b00 && tick && count_o == '0 && !wr_lo && !wr_hi)
    |=> (count_o == $past(reload_o) && irq && ovf_o)); // R5

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !wr_lo && !wr_hi) |=> $stable(count_o)); // R6

  AST_RUN_WR_KEEPS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode == 2'b00 && !tick) |=> $stable(count_o)); // R3

  AST_MEAS_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |=> !ovf_o); // R8

  AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode == 2'b11) |=> $stable(count_o)); // R10
endmodule

bind mtc_chan mtc_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .wr_lo(wr_lo),
  .wr_hi(wr_hi), .tick(tick), .count_o(count_o), .reload_o(reload_o),
  .irq(irq), .ovf_o(ovf_o));

// File: tb/mtc_chan_tb.sv
`timescale 1ns/1ps
module mtc_chan_tb;
  logic clk = 0, rst_n = 0;
  logic start = 0, edge_pol = 0, width_meas = 0;
  logic [1:0] mode = 0, clk_sel = 0;
  logic en_f1 = 0, en_f8 = 0, en_f32 = 0, en_fc32 = 0;
  logic ext_in = 0, nbr_ovf = 0, wr_lo = 0, wr_hi = 0;
  logic [7:0] wr_data = 0;
  logic [15:0] count_o, reload_o;
  logic irq, ovf_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mtc_chan u_dut (.*);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(); @(posedge clk); #1; endtask

  task automatic wr16(logic [15:0] v);
    wr_data = v[7:0];  wr_lo = 1; step(); wr_lo = 0;
    wr_data = v[15:8]; wr_hi = 1; step(); wr_hi = 0;
  endtask

  task automatic pulse(int idx);
    {en_fc32, en_f32, en_f8, en_f1} = 4'b1 << idx;
    step();
    {en_fc32, en_f32, en_f8, en_f1} = 4'b0;
  endtask

  function automatic int exp_after(int r, int n);
    if (n <= r) return r - n;
    return r - ((n - r - 1) % (r + 1));
  endfunction

  function automatic int exp_uflows(int r, int n);
    if (n <= r) return 0;
    return 1 + (n - r - 1) / (r + 1);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED));
    #5; rst_n = 1; step();
    chk("R1 count", count_o, 0); chk("R1 reload", reload_o, 0);
    chk("R1 irq", irq, 0); chk("R1 ovf", ovf_o, 0);

    wr16(16'h1234);
    chk("R2 count", count_o, 16'h1234); chk("R2 reload", reload_o, 16'h1234);

    wr16(16'd3); mode = 2'b00; clk_sel = 2'b01; start = 1;
    pulse(0); pulse(2); pulse(3);
    chk("R4 other strobes ignored", count_o, 3);
    pulse(1); chk("R4 f8 step", count_o, 2);
    pulse(1); pulse(1); chk("R4 reach zero", count_o, 0);
    pulse(1);
    chk("R5 reload", count_o, 3); chk("R5 irq", irq, 1); chk("R5 ovf", ovf_o, 1);
    step(); chk("R5 irq one cycle", irq, 0); chk("R5 ovf one cycle", ovf_o, 0);

    wr_data = 8'h09; wr_lo = 1; step(); wr_lo = 0;
    chk("R3 reload updated", reload_o, 16'h0309 & 16'h00FF | 16'h0000);
    chk("R3 count kept", count_o, 3);

    start = 0; pulse(1); pulse(1); ext_in = 1; step(); step(); step(); ext_in = 0;
    step(); step(); step();
    chk("R6 stopped hold", count_o, 3);

    wr16(16'd10); mode = 2'b01; clk_sel = 2'b00; edge_pol = 1; start = 1;
    ext_in = 1; step(); step();
    chk("R7 not yet counted", count_o, 10);
    step(); chk("R7 rising counted", count_o, 9);
    ext_in = 0; step(); step(); step(); step();
    chk("R7 falling ignored", count_o, 9);
    clk_sel = 2'b10; nbr_ovf = 1; step(); nbr_ovf = 0;
    chk("R7 neighbour step", count_o, 8);
    ext_in = 1; step(); step(); step(); step();
    chk("R7 pin ignored in cascade", count_o, 8);

    start = 0; mode = 2'b10; clk_sel = 2'b00; width_meas = 0; edge_pol = 0;
    wr16(16'd0); start = 1;
    repeat (5) pulse(0);
    chk("R8 count up", count_o, 5);
    ext_in = 0; step(); step(); step();
    chk("R8 capture", reload_o, 5); chk("R8 cleared", count_o, 0);
    chk("R8 irq", irq, 1); chk("R8 no ovf", ovf_o, 0);
    step(); chk("R8 irq one cycle", irq, 0);
    pulse(0); pulse(0);
    ext_in = 1; step(); step(); step(); step();
    chk("R8 opposite edge ignored", reload_o, 5);
    chk("R8 count kept", count_o, 2);
    ext_in = 0; step(); step(); step();
    chk("R8 second capture", reload_o, 2);

    width_meas = 1;
    repeat (4) pulse(0);
    ext_in = 1; step(); step(); step();
    chk("R9 rise capture", reload_o, 4); chk("R9 cleared", count_o, 0);
    repeat (3) pulse(0);
    ext_in = 0; step(); step(); step();
    chk("R9 fall capture", reload_o, 3);

    pulse(0); pulse(0); mode = 2'b11;
    pulse(0); pulse(1); pulse(2); pulse(3);
    chk("R10 reserved hold", count_o, 2);

    width_meas = 0; mode = 2'b00;
    for (int it = 0; it < 8; it++) begin
      int r, nt, ni;
      start = 0;
      clk_sel = 2'($urandom_range(0, 3));
      r = $urandom_range(0, 15);
      wr16(16'(r));
      start = 1; nt = 0; ni = 0;
      for (int c = 0; c < 60; c++) begin
        logic [3:0] s;
        s = 4'($urandom);
        {en_fc32, en_f32, en_f8, en_f1} = s;
        if (s[clk_sel]) nt++;
        step();
        if (irq) ni++;
      end
      {en_fc32, en_f32, en_f8, en_f1} = 4'b0;
      chk("R4 random count", count_o, exp_after(r, nt));
      chk("R5 random irq count", ni, exp_uflows(r, nt));
    end

    finish_run();
  end
endmodule